// File: doc/BRIEF.md
# Bit-Slice Carry-Lookahead ALU

This block is a purely combinational 16-bit arithmetic and logic unit with a 3-bit operation code. It is built from a single-bit slice that is instantiated once per result bit. Each slice produces the generate and propagate terms for its bit.

Those terms feed a two-level carry-lookahead tree. The first level is a row of 4-bit group units. The second level is one unit that combines the group terms and returns a carry into each group. Both levels use the same lookahead unit, unchanged.

A small decoder maps the operation code to a packed set of slice controls:
- whether the B operand enters the slice,
- whether A is inverted,
- the carry injected at bit 0,
- which slice output becomes the result.

The operations are addition, reversed subtraction (B minus A), increment of A, pass-through of A and bitwise exclusive-or. Codes that are not assigned give a defined all-zero output.

Top module: `slice_alu`

## Requirements
- R1: Code 3'd0 gives result = A + B modulo 2^16, with carryOut set to bit 16 of the unbounded sum.
- R2: Code 3'd6 gives result = B − A modulo 2^16. carryOut is 1 exactly when no borrow occurs (B ≥ A unsigned), which is bit 16 of B + ~A + 1.
- R3: Code 3'd2 gives result = A + 1 modulo 2^16, ignoring B. carryOut is 1 only when A is 16'hFFFF.
- R4: Code 3'd3 gives result = A, ignoring B, with carryOut 0.
- R5: Code 3'd1 gives result = A XOR B bit by bit, with carryOut 0.
- R6: Codes 3'd4, 3'd5 and 3'd7 give result 16'h0000 and carryOut 0 for every A and B.
- R7: Carries cross 4-bit group boundaries correctly, so a carry generated at bit 0 reaches bit 15 and carryOut in the same evaluation. For example, 16'h0FFF + 1 gives 16'h1000, and 16'hFFFF + 1 gives 16'h0000 with carryOut 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 16 | First operand (A) |
| opB | input | 16 | Second operand (B) |
| opCode | input | 3 | Operation select |
| result | output | 16 | Operation result |
| carryOut | output | 1 | Carry from bit 15 in arithmetic codes, else 0 |

## Verification
In reversed subtraction, the inversion of A inside every slice and the forced carry at bit 0 act together in a single evaluation. When A equals B, every slice propagates, so the forced carry must cross both lookahead levels in that same evaluation. The bench provokes this with equal operands and with increments of 16'hFFFF and 16'h0FFF. It judges the outcome by a zero or rolled-over result together with the expected carryOut. A table of fixed vectors is followed by a pseudo-random sweep of every code, checked against an arithmetic model kept in the bench.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    RES_SUM  = 2'd0,
    RES_PROP = 2'd1,
    RES_ZERO = 2'd2
  } resSel_e;

  typedef struct packed {
    logic    useB;
    logic    invA;
    logic    forceCin;
    resSel_e resSel;
  } sliceCtrl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [2:0] opCode,
  output sliceCtrl_t ctrl
);

  always_comb begin
    ctrl = '{useB: 1'b0, invA: 1'b0, forceCin: 1'b0, resSel: RES_ZERO};
    unique case (opCode)
      3'd0: ctrl = '{useB: 1'b1, invA: 1'b0, forceCin: 1'b0, resSel: RES_SUM};
      3'd6: ctrl = '{useB: 1'b1, invA: 1'b1, forceCin: 1'b1, resSel: RES_SUM};
      3'd2: ctrl = '{useB: 1'b0, invA: 1'b0, forceCin: 1'b1, resSel: RES_SUM};
      3'd3: ctrl = '{useB: 1'b0, invA: 1'b0, forceCin: 1'b0, resSel: RES_PROP};
      3'd1: ctrl = '{useB: 1'b1, invA: 1'b0, forceCin: 1'b0, resSel: RES_PROP};
      default: ctrl = '{useB: 1'b0, invA: 1'b0, forceCin: 1'b0, resSel: RES_ZERO};
    endcase
  end

endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic       aBit,
  input  logic       bBit,
  input  logic       cIn,
  input  sliceCtrl_t ctrl,
  output logic       gen,
  output logic       prop,
  output logic       rBit
);

  logic aEff;
  logic bEff;

  assign aEff = aBit ^ ctrl.invA;
  assign bEff = bBit & ctrl.useB;
  assign gen  = aEff & bEff;
  assign prop = aEff ^ bEff;

  always_comb begin
    unique case (ctrl.resSel)
      RES_SUM:  rBit = prop ^ cIn;
      RES_PROP: rBit = prop;
      default:  rBit = 1'b0;
    endcase
  end

endmodule

// File: rtl/cla_unit.sv
module cla_unit #(
  parameter int N = 4
) (
  input  logic [N-1:0] gIn,
  input  logic [N-1:0] pIn,
  input  logic         cin,
  output logic [N-1:0] cOut,
  output logic         gOut,
  output logic         pOut
);

  // Carry into position pos, in sum-of-products lookahead form.
  function automatic logic carryAt(input logic [N-1:0] g, input logic [N-1:0] p,
                                   input logic c0, input int pos);
    logic acc;
    logic chain;
    acc = 1'b0;
    for (int j = 0; j < pos; j++) begin
      chain = 1'b1;
      for (int k = j + 1; k < pos; k++) chain = chain & p[k];
      acc = acc | (g[j] & chain);
    end
    chain = 1'b1;
    for (int k = 0; k < pos; k++) chain = chain & p[k];
    return acc | (c0 & chain);
  endfunction

  always_comb begin
    for (int i = 0; i < N; i++) cOut[i] = carryAt(gIn, pIn, cin, i);
    gOut = carryAt(gIn, pIn, 1'b0, N);
    pOut = &pIn;
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  sliceCtrl_t       ctrl,
  output logic [WIDTH-1:0] resOut,
  output logic             carryOut
);

  localparam int NGRP = WIDTH / GROUP;

  logic [WIDTH-1:0] sliceG;
  logic [WIDTH-1:0] sliceP;
  logic [WIDTH-1:0] bitC;
  logic [NGRP-1:0]  grpG;
  logic [NGRP-1:0]  grpP;
  logic [NGRP-1:0]  grpCin;
  logic             topG;
  logic             topP;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_slice slice_i (
      .aBit(aIn[i]),
      .bBit(bIn[i]),
      .cIn (bitC[i]),
      .ctrl(ctrl),
      .gen (sliceG[i]),
      .prop(sliceP[i]),
      .rBit(resOut[i])
    );
  end

  for (genvar grp = 0; grp < NGRP; grp++) begin : g_level1
    cla_unit #(.N(GROUP)) grp_i (
      .gIn (sliceG[grp*GROUP +: GROUP]),
      .pIn (sliceP[grp*GROUP +: GROUP]),
      .cin (grpCin[grp]),
      .cOut(bitC[grp*GROUP +: GROUP]),
      .gOut(grpG[grp]),
      .pOut(grpP[grp])
    );
  end

  cla_unit #(.N(NGRP)) level2_i (
    .gIn (grpG),
    .pIn (grpP),
    .cin (ctrl.forceCin),
    .cOut(grpCin),
    .gOut(topG),
    .pOut(topP)
  );

  assign carryOut = (ctrl.resSel == RES_SUM) ? (topG | (topP & ctrl.forceCin)) : 1'b0;

  always_comb begin
    if (ctrl.resSel == RES_ZERO) begin
      // R6
      zero_mode_chk: assert (resOut == '0 && carryOut == 1'b0);
    end
    if (ctrl.resSel == RES_PROP) begin
      // R4
      logic_nocarry_chk: assert (resOut == (aIn ^ (bIn & {WIDTH{ctrl.useB}})));
    end
  end

endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [2:0]       opCode,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);

  sliceCtrl_t ctrl;

  alu_decode decode_i (
    .opCode(opCode),
    .ctrl  (ctrl)
  );

  alu_datapath #(.WIDTH(WIDTH), .GROUP(GROUP)) datapath_i (
    .aIn     (opA),
    .bIn     (opB),
    .ctrl    (ctrl),
    .resOut  (result),
    .carryOut(carryOut)
  );

  always_comb begin
    if (opCode == 3'd0) begin
      // R1
      add_sum_chk: assert ({carryOut, result} == ({1'b0, opA} + {1'b0, opB}));
    end
    if (opCode == 3'd6) begin
      // R2
      sub_rev_chk: assert ({carryOut, result} == ({1'b0, opB} + {1'b0, ~opA} + 1'b1));
    end
    if (opCode == 3'd2) begin
      // R3
      inc_chk: assert ({carryOut, result} == ({1'b0, opA} + 1'b1));
    end
    if (opCode == 3'd1) begin
      // R5
      xor_chk: assert (result == (opA ^ opB) && carryOut == 1'b0);
    end
  end

endmodule

// File: tb/slice_alu_tb_top.sv
module slice_alu_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic [2:0]  opCode = 3'd0;
  logic [15:0] result;
  logic        carryOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  slice_alu dut_i (
    .opA     (opA),
    .opB     (opB),
    .opCode  (opCode),
    .result  (result),
    .carryOut(carryOut)
  );

  // {opCode, A, B, carryOut, result}
  localparam int NV = 15;
  localparam logic [51:0] VECS [NV] = '{
    {3'd0, 16'h0001, 16'h0002, 1'b0, 16'h0003},
    {3'd0, 16'hFFFF, 16'h0001, 1'b1, 16'h0000},
    {3'd0, 16'h8000, 16'h8000, 1'b1, 16'h0000},
    {3'd0, 16'h0FFF, 16'h0001, 1'b0, 16'h1000},
    {3'd6, 16'h0003, 16'h0005, 1'b1, 16'h0002},
    {3'd6, 16'h0005, 16'h0003, 1'b0, 16'hFFFE},
    {3'd6, 16'h1234, 16'h1234, 1'b1, 16'h0000},
    {3'd2, 16'hFFFF, 16'h1234, 1'b1, 16'h0000},
    {3'd2, 16'h00FF, 16'hABCD, 1'b0, 16'h0100},
    {3'd3, 16'hA5A5, 16'h5A5A, 1'b0, 16'hA5A5},
    {3'd1, 16'hF0F0, 16'hFF00, 1'b0, 16'h0FF0},
    {3'd1, 16'hFFFF, 16'hFFFF, 1'b0, 16'h0000},
    {3'd4, 16'h1234, 16'h5678, 1'b0, 16'h0000},
    {3'd5, 16'hFFFF, 16'hFFFF, 1'b0, 16'h0000},
    {3'd7, 16'hABCD, 16'h1111, 1'b0, 16'h0000}
  };

  function automatic logic [16:0] model(input logic [2:0] op, input logic [15:0] a,
                                        input logic [15:0] b);
    case (op)
      3'd0:    return {1'b0, a} + {1'b0, b};
      3'd6:    return {1'b0, b} + {1'b0, ~a} + 17'd1;
      3'd2:    return {1'b0, a} + 17'd1;
      3'd3:    return {1'b0, a};
      3'd1:    return {1'b0, a ^ b};
      default: return 17'd0;
    endcase
  endfunction

  function automatic string reqOf(input logic [2:0] op);
    case (op)
      3'd0:    return "R1";
      3'd6:    return "R2";
      3'd2:    return "R3";
      3'd3:    return "R4";
      3'd1:    return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic apply(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic [16:0] exp, input string req);
    @(posedge clk);
    #1;
    opCode = op;
    opA = a;
    opB = b;
    @(negedge clk);
    checks++;
    if ({carryOut, result} !== exp) begin
      fails++;
      $display("FAIL %s op=%0d A=%h B=%h actual=%b_%h expected=%b_%h",
               req, op, a, b, carryOut, result, exp[16], exp[15:0]);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    // reset state: all-zero inputs, add code, give zero result and no carry (R1)
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if ({carryOut, result} !== 17'd0) begin
      fails++;
      $display("FAIL R1 reset actual=%b_%h expected=0_0000", carryOut, result);
    end
    rst = 1'b0;

    // fixed vector table
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i][51:49], VECS[i][48:33], VECS[i][32:17], VECS[i][16:0],
            reqOf(VECS[i][51:49]));
    end

    // R7: carry crossing every group boundary
    apply(3'd2, 16'h0FFF, 16'h0000, 17'h01000, "R7");
    apply(3'd2, 16'h00FF, 16'hFFFF, 17'h00100, "R7");
    apply(3'd0, 16'h7FFF, 16'h0001, 17'h08000, "R7");
    apply(3'd0, 16'hFFFF, 16'hFFFF, 17'h1FFFE, "R7");
    apply(3'd6, 16'h0000, 16'h0000, 17'h10000, "R7");

    // R3/R4: B has no effect
    apply(3'd3, 16'h1357, 16'hFFFF, 17'h01357, "R4");
    apply(3'd3, 16'h1357, 16'h0000, 17'h01357, "R4");
    apply(3'd2, 16'h4000, 16'hFFFF, 17'h04001, "R3");

    // sweep of every code with pseudo-random operands
    for (int n = 0; n < 40; n++) begin
      for (int op = 0; op < 8; op++) begin
        logic [15:0] a;
        logic [15:0] b;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        a = lfsr;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        b = lfsr ^ 16'h5A3C;
        apply(3'(op), a, b, model(3'(op), a, b), reqOf(3'(op)));
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule